// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Buffer

This block sits on the receive side of a multi-lane serial link. It takes the recovered symbols of every lane and lines them up before they go to the link layer. Each lane arrives as an 8-bit symbol with a control flag. Each lane passes through its own short delay line, and a per-lane tap picks how many symbol times that lane is held back.

After reset, or after a retrain request, the block is in a training window. It looks for an alignment marker on every lane. The lane whose marker arrives last becomes the reference, and every earlier lane is delayed by the number of symbol times it led by. Once every lane has been seen, the taps are frozen and the markers leave the block together. From then on the aligned lanes form one wide word with a valid flag. If the markers are spread too far apart to fit in the delay line, or a lane never shows its marker in time, a sticky error flag is raised and the output stays invalid.

The lane count, the symbol width, the delay-line depth and the marker code are parameters. The reference configuration is four lanes with an eight-entry line per lane.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `aligned`, `align_err` and `out_valid` are all 0.
- R2: While `aligned` is 0, `out_valid` is 0 and every bit of `out_sym` and `out_ctl` is 0.
- R3: Only a symbol with its control flag at 1 and a code equal to `MARKER` (default 8'hBC) counts as an alignment marker. A data byte of 8'hBC with its flag at 0, or a control symbol with any other code, does not count.
- R4: Let T be the clock edge that samples the last lane's first marker, with the spread within limits. After edge T, `aligned` and `out_valid` are 1, and every lane shows the marker (flag 1, code `MARKER`).
- R5: After alignment, lane l's output after edge k is the symbol lane l sampled at edge k − (T − t_l), where t_l is the edge that sampled lane l's marker. Each lane is therefore delayed by its lead over the latest lane, and the latest lane is delayed by 0.
- R6: A spread of up to DEPTH−1 (7) edges between the first and the last marker is accepted. If DEPTH (8) edges pass after the first marker before all lanes have shown one, `align_err` is 1 after that edge and `aligned` stays 0.
- R7: `align_err` stays 1, whatever the lanes carry, until reset or a retrain.
- R8: Once `aligned` is 1, later markers leave the taps unchanged and `aligned` stays 1 until reset or a retrain.
- R9: A cycle with `retrain` at 1 clears `aligned`, `align_err` and all marker records. Markers sampled in that cycle are ignored, and training restarts on the next cycle.
- R10: During training only the first marker on each lane is used. A repeated marker on a lane that has already been seen does not move that lane's arrival time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retrain | input | 1 | Synchronous request to drop alignment and train again |
| lane_sym | input | LANES*SYM_W | Incoming symbols, lane l at bits [l*SYM_W +: SYM_W] |
| lane_ctl | input | LANES | Control flag per incoming symbol |
| out_sym | output | LANES*SYM_W | Aligned symbols, same lane packing |
| out_ctl | output | LANES | Aligned control flags |
| out_valid | output | 1 | Aligned word is valid |
| aligned | output | 1 | Training finished successfully, taps frozen |
| align_err | output | 1 | Sticky: marker spread too large or a lane missing |

## Verification
The assertions assume that `rst_n` is the only asynchronous input, and that `retrain` and the lane inputs change only between clock edges. They also assume the lanes carry a single common stream that differs only by a fixed skew per lane. The claim that markers emerge together when `aligned` rises rests on that assumption. The bench keeps to it by deriving every lane from one stored reference stream shifted by that lane's skew, and by driving all inputs on the falling clock edge. Random data and random control codes other than the marker are mixed with directed skew patterns at the spread limit, one just beyond it, and one with a missing lane.

// File: rtl/lane_deskew.sv
module lane_deskew #(
  parameter int LANES = 4,
  parameter int SYM_W = 8,
  parameter int DEPTH = 8,
  parameter logic [SYM_W-1:0] MARKER = 8'hBC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   retrain,
  input  logic [LANES*SYM_W-1:0] lane_sym,
  input  logic [LANES-1:0]       lane_ctl,
  output logic [LANES*SYM_W-1:0] out_sym,
  output logic [LANES-1:0]       out_ctl,
  output logic                   out_valid,
  output logic                   aligned,
  output logic                   align_err
);

  localparam int TAP_W = $clog2(DEPTH);
  localparam int CNT_W = TAP_W + 1;
  localparam int ENT_W = SYM_W + 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

  logic             aligned_q, err_q;
  logic [LANES-1:0] found_q, hit_v;
  logic [CNT_W-1:0] since_q, cur;
  logic             training, complete, fail, done;

  assign training = !aligned_q && !err_q;
  assign cur      = (|found_q) ? since_q : '0;
  assign complete = training && (&(found_q | hit_v));
  assign fail     = training && (cur == LIMIT);
  assign done     = complete && !fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
      found_q   <= '0;
      since_q   <= '0;
    end else if (retrain) begin
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
      found_q   <= '0;
      since_q   <= '0;
    end else if (training) begin
      found_q <= found_q | hit_v;
      if (((|found_q) || (|hit_v)) && since_q != LIMIT)
        since_q <= since_q + 1'b1;
      if (fail)
        err_q <= 1'b1;
      else if (done)
        aligned_q <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [ENT_W-1:0] line_q [DEPTH];
      logic [TAP_W-1:0] tap_q;
      logic [CNT_W-1:0] arr_q, arr_now;
      logic [ENT_W-1:0] sel;

      assign hit_v[g] = training && !found_q[g] && lane_ctl[g] &&
                        (lane_sym[g*SYM_W +: SYM_W] == MARKER);
      assign arr_now  = hit_v[g] ? cur : arr_q;
      assign sel      = line_q[tap_q];
      assign out_sym[g*SYM_W +: SYM_W] = aligned_q ? sel[SYM_W-1:0] : '0;
      assign out_ctl[g] = aligned_q & sel[SYM_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
        end else begin
          line_q[0] <= {lane_ctl[g], lane_sym[g*SYM_W +: SYM_W]};
          for (int k = 1; k < DEPTH; k++) line_q[k] <= line_q[k-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tap_q <= '0;
          arr_q <= '0;
        end else if (retrain) begin
          tap_q <= '0;
          arr_q <= '0;
        end else if (training) begin
          if (hit_v[g]) arr_q <= cur;
          if (done)     tap_q <= TAP_W'(cur - arr_now);
        end
      end
    end
  endgenerate

  assign aligned   = aligned_q;
  assign align_err = err_q;
  assign out_valid = aligned_q;

endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
  parameter int LANES = 4,
  parameter int SYM_W = 8,
  parameter logic [SYM_W-1:0] MARKER = 8'hBC
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   retrain,
  input logic [LANES*SYM_W-1:0] out_sym,
  input logic [LANES-1:0]       out_ctl,
  input logic                   out_valid,
  input logic                   aligned,
  input logic                   align_err
);

  // R4
  markers_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> (out_valid && (&out_ctl) && out_sym == {LANES{MARKER}}));

  // R6
  ok_or_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(aligned && align_err));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !retrain) |=> align_err);

  // R8
  aligned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && !retrain) |=> aligned);

  // R9
  retrain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (!aligned && !align_err && !out_valid));

endmodule

bind lane_deskew lane_deskew_chk #(.LANES(LANES), .SYM_W(SYM_W), .MARKER(MARKER)) u_chk (
  .clk(clk), .rst_n(rst_n), .retrain(retrain), .out_sym(out_sym), .out_ctl(out_ctl),
  .out_valid(out_valid), .aligned(aligned), .align_err(align_err)
);

// File: tb/lane_deskew_tb.sv
module lane_deskew_tb;
  localparam int L = 4;
  localparam int M = 3;
  localparam int N = 64;
  localparam logic [7:0] MK = 8'hBC;

  logic clk = 1'b0, rst_n = 1'b0, retrain = 1'b0;
  logic [L*8-1:0] lane_sym = '0, out_sym;
  logic [L-1:0]   lane_ctl = '0, out_ctl;
  logic out_valid, aligned, align_err;

  int checks = 0, errors = 0;
  logic [7:0] rsym [N];
  logic       rctl [N];

  always #5 clk = ~clk;

  lane_deskew u_dut (.clk(clk), .rst_n(rst_n), .retrain(retrain), .lane_sym(lane_sym),
    .lane_ctl(lane_ctl), .out_sym(out_sym), .out_ctl(out_ctl), .out_valid(out_valid),
    .aligned(aligned), .align_err(align_err));

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] word_at(input int i);
    return {4'b0, {L{rctl[i]}}, {L{rsym[i]}}};
  endfunction

  function automatic logic [39:0] status();
    return {1'b0, out_valid, aligned, align_err, out_ctl, out_sym};
  endfunction

  function automatic void fill();
    for (int i = 0; i < N; i++) begin
      rctl[i] = 1'b0;
      rsym[i] = 8'($urandom);
      if ($urandom % 8 == 0) begin rctl[i] = 1'b1; rsym[i] = 8'hF7; end
    end
    rctl[0] = 1'b0; rsym[0] = MK;      // R3 data byte equal to the code
    rctl[1] = 1'b1; rsym[1] = 8'h1C;   // R3 other control code
    rctl[2] = 1'b0; rsym[2] = 8'h00;
    rctl[M] = 1'b1; rsym[M] = MK;
    rctl[M+2] = 1'b1; rsym[M+2] = MK;  // R10 repeat during training
    rctl[M+20] = 1'b1; rsym[M+20] = MK; // R8 marker after alignment
  endfunction

  task automatic run_case(input int s [L], input bit expect_ok);
    int smax = 0, smin = 1000, t_ok, t_err;
    for (int l = 0; l < L; l++) begin
      if (s[l] > smax) smax = s[l];
      if (s[l] < smin) smin = s[l];
    end
    t_ok = M + smax;
    t_err = M + smin + 8;
    fill();
    @(negedge clk);
    retrain = 1'b1;
    lane_ctl = '1;
    lane_sym = {L{MK}};
    @(posedge clk); #2;
    chk(!aligned && !align_err && !out_valid, "R9 retrain clears", status(), 40'h0);
    for (int k = 0; k < 56; k++) begin
      @(negedge clk);
      retrain = 1'b0;
      for (int l = 0; l < L; l++) begin
        int idx = k - s[l];
        if (idx >= 0 && idx < N) begin
          lane_ctl[l] = rctl[idx];
          lane_sym[l*8 +: 8] = rsym[idx];
        end else begin
          lane_ctl[l] = 1'b0;
          lane_sym[l*8 +: 8] = 8'h00;
        end
      end
      @(posedge clk); #2;
      if (expect_ok) begin
        if (k < t_ok)
          chk(!aligned && !out_valid && out_sym == '0 && out_ctl == '0 && !align_err,
              (k == t_ok - 1) ? "R3 no early lock" : "R2 gated before lock", status(), 40'h0);
        else if (k == t_ok)
          chk(aligned && out_valid && {out_ctl, out_sym} == word_at(M),
              "R4 markers leave together", status(), word_at(M));
        else
          chk(aligned && out_valid && !align_err && {out_ctl, out_sym} == word_at(k - smax),
              (k >= M + 20 + smax) ? "R8 taps frozen" : "R5 R10 aligned stream",
              status(), word_at(k - smax));
      end else begin
        if (k < t_err)
          chk(!align_err && !aligned && !out_valid, "R6 no early error", status(), 40'h0);
        else
          chk(align_err && !aligned && !out_valid && out_ctl == '0,
              (k == t_err) ? "R6 spread error" : "R7 error sticky", status(), 40'h0);
      end
    end
  endtask

  initial begin
    int s [L];
    void'($urandom(32'd4242));
    #12;
    chk(!aligned && !align_err && !out_valid, "R1 reset state", status(), 40'h0);
    @(negedge clk); rst_n = 1'b1;
    s = '{0, 0, 0, 0}; run_case(s, 1'b1);
    s = '{0, 1, 2, 6}; run_case(s, 1'b1);
    s = '{7, 0, 3, 5}; run_case(s, 1'b1);
    for (int r = 0; r < 4; r++) begin
      for (int l = 0; l < L; l++) s[l] = int'($urandom % 8);
      run_case(s, 1'b1);
    end
    s = '{0, 8, 2, 3}; run_case(s, 1'b0);
    s = '{1, 2, 3, 30}; run_case(s, 1'b0);
    s = '{2, 5, 0, 4}; run_case(s, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule